// File: doc/BRIEF.md
# Early Load Validity Tracker

This block keeps a small record of loads that a processor has issued ahead of their program position. When such a load finishes without error, the block records the destination register number and the address that was read. Every store that the core retires is compared against the recorded addresses. Any entry whose address the store overlaps is removed, because the value held in its register may now be out of date. A faulting early load records nothing.

Later in the instruction stream, a check operation names a register. If a valid entry for that register is still present, the speculative value is trustworthy and execution continues (pass). If the entry is gone, because a store overlapped it, the load faulted, the entry was replaced, or the table was flushed, the core must branch to its recovery sequence (recover). The memory system and the recovery code are outside this block.

The table is fully associative. Addresses are compared at 8-byte granularity. A flush input empties the whole table in one cycle.

Top module: `early_load_tracker`

## Requirements
- R1: After reset every entry is invalid, so a check on any register reports recover.
- R2: An allocation with `allocValid`=1 and `allocFault`=0 records `allocReg` and `allocAddr`. A check on that register in any later cycle reports `checkPass`=1 and `checkRecover`=0, provided nothing has removed the entry.
- R3: An allocation with `allocFault`=1 creates no entry. It also removes any existing entry for the same register, so a later check on that register reports recover.
- R4: A store with `storeValid`=1 removes every valid entry whose address bits [ADDR_W-1:3] equal those of `storeAddr`. Addresses that differ only in bits [2:0] match. Addresses that differ in any higher bit do not match.
- R5: While `checkValid`=1, exactly one of `checkPass` and `checkRecover` is 1: pass when a valid entry holds `checkReg`, recover otherwise. While `checkValid`=0, both outputs are 0.
- R6: A successful allocation to a register that already has an entry overwrites that entry in place. After that, a store to the old address has no effect on it, and a store to the new address removes it.
- R7: A new register takes the lowest-indexed invalid entry when one exists. When all entries are valid, it replaces the entry selected by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one only on such a replacement, not on an in-place overwrite. A check on an evicted register reports recover.
- R8: When a store and a successful allocation occur in the same cycle at the same address, the store is treated as older. The new entry survives, and other entries at that address are removed.
- R9: A flush removes all entries in one cycle and takes priority over an allocation in the same cycle, which is discarded.
- R10: A check sees the table as it was at the start of its cycle. A check in the same cycle as the allocation for its register reports recover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every entry |
| allocValid | input | 1 | An early load completes this cycle |
| allocFault | input | 1 | That early load faulted |
| allocReg | input | REG_W | Destination register of the early load |
| allocAddr | input | ADDR_W | Address read by the early load |
| storeValid | input | 1 | A store snoop this cycle |
| storeAddr | input | ADDR_W | Store address |
| checkValid | input | 1 | A check operation this cycle |
| checkReg | input | REG_W | Register being checked |
| checkPass | output | 1 | Entry present, speculation valid |
| checkRecover | output | 1 | Entry missing, branch to recovery |

## Verification
The hardest situation to reach from the ports is round-robin replacement. It only occurs once all sixteen entries hold distinct registers, and the bench cannot see which entry a register occupies. The stimulus therefore resets the block, fills it with registers 0 to 15 in order so that each entry's position is known, then allocates two new registers. It checks that exactly registers 0 and 1 were evicted. An in-place overwrite of register 3, followed by one more new register, then shows that the pointer did not move on the overwrite, because register 2 rather than register 3 is the one evicted.

// File: rtl/elt_pkg.sv
package elt_pkg;

  // Strobes from the control to the entry datapath, one per update kind.
  typedef struct packed {
    logic clearAll;   // flush every entry
    logic snoopEn;    // apply the store address compare
    logic writeEn;    // write the entry selected by writeIdx
    logic dropRegEn;  // remove the entry holding allocReg (faulting load)
  } tableStrobes_t;

endpackage

// File: rtl/elt_ctrl.sv
module elt_ctrl
  import elt_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               allocValid,
  input  logic               allocFault,
  input  logic               storeValid,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] allocRegHit,
  output tableStrobes_t      strobes,
  output logic [IDX_W-1:0]   writeIdx
);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] hitIdx;
  logic [IDX_W-1:0] freeIdx;
  logic             anyHit;
  logic             anyFree;
  logic             loadOk;
  logic             replaceUsed;

  // Lowest-indexed register hit and lowest-indexed free entry.
  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    anyHit  = 1'b0;
    anyFree = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (allocRegHit[i]) begin
        hitIdx = IDX_W'(i);
        anyHit = 1'b1;
      end
      if (!validVec[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  assign loadOk = allocValid && !allocFault;

  always_comb begin
    strobes.clearAll  = flush;
    strobes.snoopEn   = storeValid && !flush;
    strobes.writeEn   = loadOk && !flush;
    strobes.dropRegEn = allocValid && allocFault && !flush;
  end

  always_comb begin
    if (anyHit)       writeIdx = hitIdx;
    else if (anyFree) writeIdx = freeIdx;
    else              writeIdx = rrPtr;
  end

  assign replaceUsed = strobes.writeEn && !anyHit && !anyFree;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (replaceUsed) begin
      if (rrPtr == IDX_W'(ENTRIES - 1)) rrPtr <= '0;
      else                              rrPtr <= rrPtr + 1'b1;
    end
  end

endmodule

// File: rtl/elt_datapath.sv
module elt_datapath
  import elt_pkg::*;
#(
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned REG_W     = 7,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAN_BITS = 3,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned TAG_W = ADDR_W - GRAN_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  tableStrobes_t      strobes,
  input  logic [IDX_W-1:0]   writeIdx,
  input  logic [REG_W-1:0]   allocReg,
  input  logic [ADDR_W-1:0]  allocAddr,
  input  logic [ADDR_W-1:0]  storeAddr,
  input  logic [REG_W-1:0]   checkReg,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] allocRegHit,
  output logic               checkHit
);

  logic             entValid [ENTRIES];
  logic [REG_W-1:0] entReg   [ENTRIES];
  logic [TAG_W-1:0] entTag   [ENTRIES];

  logic [ENTRIES-1:0] storeHit;
  logic [ENTRIES-1:0] checkHitVec;
  logic [TAG_W-1:0]   storeTag;
  logic [TAG_W-1:0]   allocTag;

  assign storeTag = storeAddr[ADDR_W-1:GRAN_BITS];
  assign allocTag = allocAddr[ADDR_W-1:GRAN_BITS];

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_entry
    logic selWrite;

    assign validVec[gi]    = entValid[gi];
    assign storeHit[gi]    = entValid[gi] && (entTag[gi] == storeTag);
    assign allocRegHit[gi] = entValid[gi] && (entReg[gi] == allocReg);
    assign checkHitVec[gi] = entValid[gi] && (entReg[gi] == checkReg);
    assign selWrite        = strobes.writeEn && (writeIdx == IDX_W'(gi));

    // Write beats the store snoop: the store is the older operation.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid[gi] <= 1'b0;
      end else if (strobes.clearAll) begin
        entValid[gi] <= 1'b0;
      end else if (selWrite) begin
        entValid[gi] <= 1'b1;
      end else if ((strobes.snoopEn && storeHit[gi]) ||
                   (strobes.dropRegEn && allocRegHit[gi])) begin
        entValid[gi] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (selWrite && !strobes.clearAll) begin
        entReg[gi] <= allocReg;
        entTag[gi] <= allocTag;
      end
    end
  end

  assign checkHit = |checkHitVec;

endmodule

// File: rtl/early_load_tracker.sv
module early_load_tracker
  import elt_pkg::*;
#(
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned REG_W     = 7,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAN_BITS = 3,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              allocValid,
  input  logic              allocFault,
  input  logic [REG_W-1:0]  allocReg,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic              storeValid,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic              checkValid,
  input  logic [REG_W-1:0]  checkReg,
  output logic              checkPass,
  output logic              checkRecover
);

  tableStrobes_t      strobes;
  logic [IDX_W-1:0]   writeIdx;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] allocRegHit;
  logic               checkHit;

  elt_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .flush      (flush),
    .allocValid (allocValid),
    .allocFault (allocFault),
    .storeValid (storeValid),
    .validVec   (validVec),
    .allocRegHit(allocRegHit),
    .strobes    (strobes),
    .writeIdx   (writeIdx)
  );

  elt_datapath #(
    .ENTRIES  (ENTRIES),
    .REG_W    (REG_W),
    .ADDR_W   (ADDR_W),
    .GRAN_BITS(GRAN_BITS)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .writeIdx   (writeIdx),
    .allocReg   (allocReg),
    .allocAddr  (allocAddr),
    .storeAddr  (storeAddr),
    .checkReg   (checkReg),
    .validVec   (validVec),
    .allocRegHit(allocRegHit),
    .checkHit   (checkHit)
  );

  assign checkPass    = checkValid && checkHit;
  assign checkRecover = checkValid && !checkHit;

endmodule

// File: rtl/elt_checker.sv
module elt_checker #(
  parameter int unsigned REG_W  = 7,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              flush,
  input logic              allocValid,
  input logic              allocFault,
  input logic [REG_W-1:0]  allocReg,
  input logic              checkValid,
  input logic [REG_W-1:0]  checkReg,
  input logic              checkPass,
  input logic              checkRecover
);

  assert_one_answer_R5: assert property (@(posedge clk) disable iff (!rstN)
    checkValid |-> (checkPass ^ checkRecover));

  assert_quiet_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !checkValid |-> (!checkPass && !checkRecover));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !checkPass);

  assert_alloc_visible_R2: assert property (@(posedge clk) disable iff (!rstN)
    (checkValid && $past(allocValid && !allocFault && !flush && rstN) &&
     checkReg == $past(allocReg)) |-> checkPass);

  assert_fault_leaves_none_R3: assert property (@(posedge clk) disable iff (!rstN)
    (checkValid && $past(allocValid && allocFault && rstN) &&
     checkReg == $past(allocReg)) |-> checkRecover);

endmodule

bind early_load_tracker elt_checker #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .flush       (flush),
  .allocValid  (allocValid),
  .allocFault  (allocFault),
  .allocReg    (allocReg),
  .checkValid  (checkValid),
  .checkReg    (checkReg),
  .checkPass   (checkPass),
  .checkRecover(checkRecover)
);

// File: tb/early_load_tracker_bench.sv
module early_load_tracker_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        allocValid = 1'b0;
  logic        allocFault = 1'b0;
  logic [6:0]  allocReg = '0;
  logic [31:0] allocAddr = '0;
  logic        storeValid = 1'b0;
  logic [31:0] storeAddr = '0;
  logic        checkValid = 1'b0;
  logic [6:0]  checkReg = '0;
  logic        checkPass;
  logic        checkRecover;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  early_load_tracker u_early_load_tracker (
    .clk(clk), .rstN(rstN), .flush(flush),
    .allocValid(allocValid), .allocFault(allocFault),
    .allocReg(allocReg), .allocAddr(allocAddr),
    .storeValid(storeValid), .storeAddr(storeAddr),
    .checkValid(checkValid), .checkReg(checkReg),
    .checkPass(checkPass), .checkRecover(checkRecover)
  );

  typedef struct packed {
    logic        fl;
    logic        aV;
    logic        aF;
    logic [6:0]  aR;
    logic [31:0] aA;
    logic        sV;
    logic [31:0] sA;
    logic        cV;
    logic [6:0]  cR;
    logic        eP;
    logic        eR;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  // Each vector is one cycle; expected outputs reflect the table before its edge.
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,7'd0, 32'h0,  1'b0,32'h0,  1'b1,7'd5, 1'b0,1'b1,8'd1},  // R1 empty
    '{1'b0,1'b1,1'b0,7'd5, 32'h100,1'b0,32'h0,  1'b1,7'd5, 1'b0,1'b1,8'd10}, // R10 same cycle
    '{1'b0,1'b0,1'b0,7'd0, 32'h0,  1'b0,32'h0,  1'b1,7'd5, 1'b1,1'b0,8'd2},  // R2
    '{1'b0,1'b0,1'b0,7'd0, 32'h0,  1'b1,32'h104,1'b1,7'd5, 1'b1,1'b0,8'd4},  // R4 store same granule
    '{1'b0,1'b0,1'b0,7'd0, 32'h0,  1'b0,32'h0,  1'b1,7'd5, 1'b0,1'b1,8'd4},  // R4 removed
    '{1'b0,1'b1,1'b0,7'd6, 32'h200,1'b0,32'h0,  1'b0,7'd0, 1'b0,1'b0,8'd5},  // R5 idle
    '{1'b0,1'b0,1'b0,7'd0, 32'h0,  1'b1,32'h208,1'b1,7'd6, 1'b1,1'b0,8'd4},  // R4 other granule
    '{1'b0,1'b0,1'b0,7'd0, 32'h0,  1'b0,32'h0,  1'b1,7'd6, 1'b1,1'b0,8'd4},  // R4 kept
    '{1'b0,1'b1,1'b1,7'd6, 32'h300,1'b0,32'h0,  1'b1,7'd6, 1'b1,1'b0,8'd3},  // R3 fault
    '{1'b0,1'b0,1'b0,7'd0, 32'h0,  1'b0,32'h0,  1'b1,7'd6, 1'b0,1'b1,8'd3},  // R3 dropped
    '{1'b0,1'b1,1'b0,7'd7, 32'h400,1'b0,32'h0,  1'b0,7'd0, 1'b0,1'b0,8'd5},  // R5 idle
    '{1'b0,1'b1,1'b0,7'd7, 32'h500,1'b0,32'h0,  1'b1,7'd7, 1'b1,1'b0,8'd6},  // R6 overwrite
    '{1'b0,1'b0,1'b0,7'd0, 32'h0,  1'b1,32'h400,1'b1,7'd7, 1'b1,1'b0,8'd6},  // R6 old addr store
    '{1'b0,1'b0,1'b0,7'd0, 32'h0,  1'b0,32'h0,  1'b1,7'd7, 1'b1,1'b0,8'd6},  // R6 unaffected
    '{1'b0,1'b0,1'b0,7'd0, 32'h0,  1'b1,32'h500,1'b0,7'd0, 1'b0,1'b0,8'd6},  // R6 new addr store
    '{1'b0,1'b0,1'b0,7'd0, 32'h0,  1'b0,32'h0,  1'b1,7'd7, 1'b0,1'b1,8'd6},  // R6 removed
    '{1'b0,1'b1,1'b0,7'd8, 32'h600,1'b1,32'h600,1'b0,7'd0, 1'b0,1'b0,8'd8},  // R8 same cycle
    '{1'b0,1'b0,1'b0,7'd0, 32'h0,  1'b0,32'h0,  1'b1,7'd8, 1'b1,1'b0,8'd8},  // R8 survives
    '{1'b0,1'b1,1'b0,7'd9, 32'h700,1'b0,32'h0,  1'b0,7'd0, 1'b0,1'b0,8'd8},
    '{1'b0,1'b1,1'b0,7'd10,32'h700,1'b1,32'h704,1'b1,7'd9, 1'b1,1'b0,8'd8},  // R8
    '{1'b0,1'b0,1'b0,7'd0, 32'h0,  1'b0,32'h0,  1'b1,7'd9, 1'b0,1'b1,8'd8},  // R8 older removed
    '{1'b0,1'b0,1'b0,7'd0, 32'h0,  1'b0,32'h0,  1'b1,7'd10,1'b1,1'b0,8'd8},  // R8 new kept
    '{1'b1,1'b1,1'b0,7'd11,32'h800,1'b0,32'h0,  1'b1,7'd10,1'b1,1'b0,8'd9},  // R9 flush
    '{1'b0,1'b0,1'b0,7'd0, 32'h0,  1'b0,32'h0,  1'b1,7'd10,1'b0,1'b1,8'd9},  // R9 cleared
    '{1'b0,1'b1,1'b1,7'd12,32'h900,1'b0,32'h0,  1'b1,7'd11,1'b0,1'b1,8'd9},  // R9 alloc discarded
    '{1'b0,1'b0,1'b0,7'd0, 32'h0,  1'b0,32'h0,  1'b1,7'd12,1'b0,1'b1,8'd3},  // R3 nothing created
    '{1'b0,1'b0,1'b0,7'd0, 32'h0,  1'b0,32'h0,  1'b1,7'd8, 1'b0,1'b1,8'd9}   // R9 all gone
  };

  task automatic drive(input logic fl, input logic aV, input logic aF,
                       input logic [6:0] aR, input logic [31:0] aA,
                       input logic sV, input logic [31:0] sA,
                       input logic cV, input logic [6:0] cR);
    @(negedge clk);
    flush = fl; allocValid = aV; allocFault = aF; allocReg = aR; allocAddr = aA;
    storeValid = sV; storeAddr = sA; checkValid = cV; checkReg = cR;
  endtask

  task automatic expect2(input logic eP, input logic eR, input string req);
    #1;
    checks++;
    if (checkPass !== eP || checkRecover !== eR) begin
      errors++;
      $display("FAIL %s: pass/recover = %b%b, expected %b%b", req, checkPass, checkRecover, eP, eR);
    end
  endtask

  task automatic alloc(input logic [6:0] r, input logic [31:0] a);
    drive(1'b0, 1'b1, 1'b0, r, a, 1'b0, 32'h0, 1'b0, 7'd0);
  endtask

  task automatic probe(input logic [6:0] r, input logic eP, input string req);
    drive(1'b0, 1'b0, 1'b0, 7'd0, 32'h0, 1'b0, 32'h0, 1'b1, r);
    expect2(eP, !eP, req);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    flush = 1'b0; allocValid = 1'b0; storeValid = 1'b0; checkValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].fl, VECS[i].aV, VECS[i].aF, VECS[i].aR, VECS[i].aA,
            VECS[i].sV, VECS[i].sA, VECS[i].cV, VECS[i].cR);
      expect2(VECS[i].eP, VECS[i].eR, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R1: reset removes a live entry
    alloc(7'd50, 32'hA00);
    probe(7'd50, 1'b1, "R2 before reset");
    doReset();
    probe(7'd50, 1'b0, "R1 after reset");

    // R7: fill all entries, then replace round-robin
    doReset();
    for (int r = 0; r < 16; r++) alloc(7'(r), 32'h1000 + 32'(r) * 32'h10);
    for (int r = 0; r < 16; r++) probe(7'(r), 1'b1, "R7 full table holds all");
    alloc(7'd40, 32'h2000);
    alloc(7'd41, 32'h2010);
    probe(7'd0, 1'b0, "R7 reg0 evicted");
    probe(7'd1, 1'b0, "R7 reg1 evicted");
    probe(7'd2, 1'b1, "R7 reg2 kept");
    probe(7'd40, 1'b1, "R7 reg40 present");
    probe(7'd41, 1'b1, "R7 reg41 present");
    alloc(7'd3, 32'h2100);   // overwrite in place, pointer stays at entry 2
    alloc(7'd43, 32'h2200);
    probe(7'd2, 1'b0, "R7 reg2 evicted after overwrite");
    probe(7'd3, 1'b1, "R7 reg3 kept, R6 overwrite in place");
    drive(1'b0, 1'b0, 1'b0, 7'd0, 32'h0, 1'b0, 32'h0, 1'b0, 7'd0);
    expect2(1'b0, 1'b0, "R5 idle outputs");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule